// File: doc/BRIEF.md
# Configuration-Driven Address Region Decoder

This block turns a 16-bit processor address and the active 8-bit configuration byte into a set of one-hot device selects and a RAM bank number. The address space is split into four 16K windows. Each window above the bottom one has its own field in the configuration byte, and that field picks the device that answers there. Two smaller ranges are carved out of the top window. A 4K page holds the I/O devices and has its own enable bit. A five-byte range at the top of the map always reaches the configuration register mirror, so software can change the configuration from any memory layout.

The decoder is purely combinational. A system places it between the processor address bus and the memory and peripheral chip selects. The configuration register that feeds it lives elsewhere, and so do the memory devices.

Top module: `addrRegionDecoder`

## Requirements
- R1: Addresses 0x0000 to 0x3FFF assert selRam for every configuration value.
- R2: In 0x4000 to 0x7FFF, bit 1 of cfgByte set to 0 asserts selLoRom and set to 1 asserts selRam.
- R3: In 0x8000 to 0xBFFF, cfgByte[3:2] picks the device: 00 selHiRom, 01 selIntRom, 10 selExtRom, 11 selRam.
- R4: In 0xC000 to 0xFFFF, outside the I/O page and the mirror range, cfgByte[5:4] picks the device: 00 selTopRom, 01 selIntRom, 10 selExtRom, 11 selRam.
- R5: In 0xD000 to 0xDFFF with cfgByte[0] = 0, selIo is asserted whatever cfgByte[5:4] holds.
- R6: In 0xD000 to 0xDFFF with cfgByte[0] = 1, cfgByte[5:4] = 00 asserts selCharRom, and the other codes select as in R4.
- R7: Addresses 0xFF00 to 0xFF04 assert selMirror for every configuration value, and 0xFF05 decodes as in R4.
- R8: ramBank equals cfgByte[7:6] while selRam is asserted and is 0 otherwise.
- R9: Exactly one of the nine select outputs is asserted for every address and configuration pair.
- R10: A configuration value of 0x10 gives selIo at 0xD000, selLoRom at 0x4000, selHiRom at 0x8000, selIntRom at 0xC000 and 0xE000, and selRam with ramBank 0 at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuAddr | input | 16 | Processor address |
| cfgByte | input | 8 | Active configuration byte |
| selIo | output | 1 | I/O page select |
| selLoRom | output | 1 | Low system ROM select |
| selHiRom | output | 1 | High system ROM select |
| selIntRom | output | 1 | Internal function ROM select |
| selExtRom | output | 1 | External function ROM select |
| selTopRom | output | 1 | Upper system ROM select |
| selCharRom | output | 1 | Character ROM select |
| selRam | output | 1 | RAM select |
| selMirror | output | 1 | Configuration register mirror select |
| ramBank | output | 2 | RAM bank number for a RAM access |

## Verification
Every output is due in the same cycle as its inputs, because there is no register between cpuAddr or cfgByte and any select or ramBank. The bench changes the inputs on the falling clock edge and samples a quarter period later, so each check sees settled logic well before the next rising edge. The bench computes the expected select and bank from the requirements, and the address and configuration ranges it sweeps cover every field code at every window edge.

// File: rtl/regionDecodePkg.sv
package regionDecodePkg;

  localparam int SEL_IO      = 0;
  localparam int SEL_LOROM   = 1;
  localparam int SEL_HIROM   = 2;
  localparam int SEL_INTROM  = 3;
  localparam int SEL_EXTROM  = 4;
  localparam int SEL_TOPROM  = 5;
  localparam int SEL_CHARROM = 6;
  localparam int SEL_RAM     = 7;
  localparam int SEL_MIRROR  = 8;
  localparam int NUM_SEL     = 9;

  typedef logic [NUM_SEL-1:0] selVec_t;

  // Field codes shared by the two switchable windows.
  typedef enum logic [1:0] {
    SRC_SYSTEM = 2'b00,
    SRC_INTFN  = 2'b01,
    SRC_EXTFN  = 2'b10,
    SRC_RAM    = 2'b11
  } srcCode_t;

  // Region strobes from the address decode to the select datapath.
  typedef struct packed {
    logic inLow;     // bottom 16K window
    logic inMid;     // second 16K window
    logic inHigh;    // third 16K window
    logic inTop;     // top 16K window, mirror excluded
    logic inIoPage;  // 4K I/O page inside the top window
    logic inMirror;  // register mirror range
  } regionStrobes_t;

endpackage

// File: rtl/regionAddrCtrl.sv
module regionAddrCtrl
  import regionDecodePkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int IO_PAGE      = 13,
  parameter int MIRROR_PAGE  = 255,
  parameter int MIRROR_COUNT = 5
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  output regionStrobes_t    strobes
);

  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [3:0]        IO_NIB     = 4'(IO_PAGE);
  localparam logic [PAGE_W-1:0] MIR_PAGE_V = PAGE_W'(MIRROR_PAGE);
  localparam logic [7:0]        MIR_LIMIT  = 8'(MIRROR_COUNT);

  logic [1:0] windowIdx;
  logic       mirrorHit;

  assign windowIdx = cpuAddr[ADDR_W-1 -: 2];
  assign mirrorHit = (cpuAddr[ADDR_W-1:8] == MIR_PAGE_V) && (cpuAddr[7:0] < MIR_LIMIT);

  always_comb begin
    strobes          = '0;
    strobes.inMirror = mirrorHit;
    strobes.inIoPage = (cpuAddr[ADDR_W-1 -: 4] == IO_NIB);
    unique case (windowIdx)
      2'd0: strobes.inLow  = 1'b1;
      2'd1: strobes.inMid  = 1'b1;
      2'd2: strobes.inHigh = 1'b1;
      default: strobes.inTop = !mirrorHit;
    endcase
  end

endmodule

// File: rtl/regionSelectPath.sv
module regionSelectPath
  import regionDecodePkg::*;
(
  input  regionStrobes_t strobes,
  input  logic [7:0]     cfgByte,
  output selVec_t        selVec,
  output logic [1:0]     ramBank
);

  logic       ioEnableN;
  logic       loRamEn;
  srcCode_t   highCode;
  srcCode_t   topCode;

  assign ioEnableN = cfgByte[0];
  assign loRamEn   = cfgByte[1];
  assign highCode  = srcCode_t'(cfgByte[3:2]);
  assign topCode   = srcCode_t'(cfgByte[5:4]);

  function automatic selVec_t fieldToSel(srcCode_t code, int sysIdx);
    selVec_t s;
    s = '0;
    unique case (code)
      SRC_SYSTEM: s[sysIdx]     = 1'b1;
      SRC_INTFN:  s[SEL_INTROM] = 1'b1;
      SRC_EXTFN:  s[SEL_EXTROM] = 1'b1;
      default:    s[SEL_RAM]    = 1'b1;
    endcase
    return s;
  endfunction

  always_comb begin
    selVec = '0;
    if (strobes.inMirror) begin
      selVec[SEL_MIRROR] = 1'b1;
    end else if (strobes.inLow) begin
      selVec[SEL_RAM] = 1'b1;
    end else if (strobes.inMid) begin
      if (loRamEn) selVec[SEL_RAM] = 1'b1;
      else         selVec[SEL_LOROM] = 1'b1;
    end else if (strobes.inHigh) begin
      selVec = fieldToSel(highCode, SEL_HIROM);
    end else if (strobes.inIoPage && !ioEnableN) begin
      selVec[SEL_IO] = 1'b1;
    end else if (strobes.inIoPage) begin
      selVec = fieldToSel(topCode, SEL_CHARROM);
    end else begin
      selVec = fieldToSel(topCode, SEL_TOPROM);
    end
  end

  assign ramBank = selVec[SEL_RAM] ? cfgByte[7:6] : 2'b00;

endmodule

// File: rtl/addrRegionDecoder.sv
module addrRegionDecoder
  import regionDecodePkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MIRROR_COUNT = 5
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cfgByte,
  output logic              selIo,
  output logic              selLoRom,
  output logic              selHiRom,
  output logic              selIntRom,
  output logic              selExtRom,
  output logic              selTopRom,
  output logic              selCharRom,
  output logic              selRam,
  output logic              selMirror,
  output logic [1:0]        ramBank
);

  localparam int TOP_PAGE = (1 << (ADDR_W - 8)) - 1;
  localparam int IO_NIB   = 13;

  regionStrobes_t strobes;
  selVec_t        selVec;

  regionAddrCtrl #(
    .ADDR_W      (ADDR_W),
    .IO_PAGE     (IO_NIB),
    .MIRROR_PAGE (TOP_PAGE),
    .MIRROR_COUNT(MIRROR_COUNT)
  ) ctrl_i (
    .cpuAddr(cpuAddr),
    .strobes(strobes)
  );

  regionSelectPath path_i (
    .strobes(strobes),
    .cfgByte(cfgByte),
    .selVec (selVec),
    .ramBank(ramBank)
  );

  assign selIo      = selVec[SEL_IO];
  assign selLoRom   = selVec[SEL_LOROM];
  assign selHiRom   = selVec[SEL_HIROM];
  assign selIntRom  = selVec[SEL_INTROM];
  assign selExtRom  = selVec[SEL_EXTROM];
  assign selTopRom  = selVec[SEL_TOPROM];
  assign selCharRom = selVec[SEL_CHARROM];
  assign selRam     = selVec[SEL_RAM];
  assign selMirror  = selVec[SEL_MIRROR];

endmodule

// File: rtl/regionDecodeChecker.sv
module regionDecodeChecker (
  input logic [15:0] cpuAddr,
  input logic [7:0]  cfgByte,
  input logic        selIo,
  input logic        selLoRom,
  input logic        selHiRom,
  input logic        selIntRom,
  input logic        selExtRom,
  input logic        selTopRom,
  input logic        selCharRom,
  input logic        selRam,
  input logic        selMirror,
  input logic [1:0]  ramBank
);

  logic [8:0] allSel;
  assign allSel = {selMirror, selRam, selCharRom, selTopRom, selExtRom,
                   selIntRom, selHiRom, selLoRom, selIo};

  always_comb begin
    AST_SINGLE_SELECT: assert ($countones(allSel) == 1) else $error("select count"); // R9
    if (cpuAddr < 16'h4000)
      AST_BOTTOM_RAM: assert (selRam) else $error("bottom window"); // R1
    if (cpuAddr >= 16'h4000 && cpuAddr < 16'h8000 && !cfgByte[1])
      AST_LOW_ROM: assert (selLoRom) else $error("low window"); // R2
    if (cpuAddr >= 16'hD000 && cpuAddr < 16'hE000 && !cfgByte[0])
      AST_IO_OVERRIDE: assert (selIo) else $error("io page"); // R5
    if (cpuAddr >= 16'hFF00 && cpuAddr <= 16'hFF04)
      AST_MIRROR_FIXED: assert (selMirror) else $error("mirror range"); // R7
    if (!selRam)
      AST_BANK_IDLE: assert (ramBank == 2'b00) else $error("bank idle"); // R8
    if (selRam)
      AST_BANK_FOLLOWS: assert (ramBank == cfgByte[7:6]) else $error("bank value"); // R8
  end

endmodule

bind addrRegionDecoder regionDecodeChecker chk_i (
  .cpuAddr   (cpuAddr),
  .cfgByte   (cfgByte),
  .selIo     (selIo),
  .selLoRom  (selLoRom),
  .selHiRom  (selHiRom),
  .selIntRom (selIntRom),
  .selExtRom (selExtRom),
  .selTopRom (selTopRom),
  .selCharRom(selCharRom),
  .selRam    (selRam),
  .selMirror (selMirror),
  .ramBank   (ramBank)
);

// File: tb/addrRegionDecoder_tb.sv
`timescale 1ns/1ps
module addrRegionDecoder_tb_top;

  // Bit order of expected vectors:
  // {mirror, ram, char, top, ext, int, hi, lo, io}
  localparam logic [8:0] E_IO   = 9'b000000001;
  localparam logic [8:0] E_LO   = 9'b000000010;
  localparam logic [8:0] E_HI   = 9'b000000100;
  localparam logic [8:0] E_INT  = 9'b000001000;
  localparam logic [8:0] E_EXT  = 9'b000010000;
  localparam logic [8:0] E_TOP  = 9'b000100000;
  localparam logic [8:0] E_CHAR = 9'b001000000;
  localparam logic [8:0] E_RAM  = 9'b010000000;
  localparam logic [8:0] E_MIR  = 9'b100000000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cpuAddr = '0;
  logic [7:0]  cfgByte = '0;
  logic selIo, selLoRom, selHiRom, selIntRom, selExtRom;
  logic selTopRom, selCharRom, selRam, selMirror;
  logic [1:0] ramBank;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  addrRegionDecoder dut_i (
    .cpuAddr(cpuAddr), .cfgByte(cfgByte),
    .selIo(selIo), .selLoRom(selLoRom), .selHiRom(selHiRom),
    .selIntRom(selIntRom), .selExtRom(selExtRom), .selTopRom(selTopRom),
    .selCharRom(selCharRom), .selRam(selRam), .selMirror(selMirror),
    .ramBank(ramBank)
  );

  function automatic logic [8:0] fieldPick(logic [1:0] code, logic [8:0] sysSel);
    case (code)
      2'b00:   return sysSel;
      2'b01:   return E_INT;
      2'b10:   return E_EXT;
      default: return E_RAM;
    endcase
  endfunction

  function automatic logic [8:0] expectSel(logic [15:0] a, logic [7:0] c);
    if (a >= 16'hFF00 && a <= 16'hFF04)             return E_MIR;   // R7
    if (a < 16'h4000)                                return E_RAM;   // R1
    if (a < 16'h8000)                                return c[1] ? E_RAM : E_LO; // R2
    if (a < 16'hC000)                                return fieldPick(c[3:2], E_HI); // R3
    if (a >= 16'hD000 && a < 16'hE000 && !c[0])     return E_IO;    // R5
    if (a >= 16'hD000 && a < 16'hE000)              return fieldPick(c[5:4], E_CHAR); // R6
    return fieldPick(c[5:4], E_TOP);                                 // R4
  endfunction

  function automatic logic [8:0] actualSel();
    return {selMirror, selRam, selCharRom, selTopRom, selExtRom,
            selIntRom, selHiRom, selLoRom, selIo};
  endfunction

  task automatic applyAndCheck(input logic [15:0] a, input logic [7:0] c, input string tag);
    logic [8:0] expS;
    logic [1:0] expB;
    @(negedge clk);
    cpuAddr = a;
    cfgByte = c;
    #5;
    expS = expectSel(a, c);
    expB = expS[7] ? c[7:6] : 2'b00;
    checks++;
    if (actualSel() !== expS) begin
      fails++;
      $display("FAIL %s addr=%h cfg=%h selects actual=%b expected=%b", tag, a, c, actualSel(), expS);
    end
    checks++;
    if (ramBank !== expB) begin
      fails++;
      $display("FAIL R8 addr=%h cfg=%h ramBank actual=%0d expected=%0d", a, c, ramBank, expB);
    end
    checks++;
    if ($countones(actualSel()) != 1) begin
      fails++;
      $display("FAIL R9 addr=%h cfg=%h selects actual=%b expected=one hot", a, c, actualSel());
    end
  endtask

  task automatic testInitial();
    applyAndCheck(16'h0000, 8'h00, "R1 initial");
  endtask

  task automatic testBottom();
    for (int c = 0; c < 256; c += 17) applyAndCheck(16'h3FFF, 8'(c), "R1");
    applyAndCheck(16'h1234, 8'hFF, "R1");
  endtask

  task automatic testLowWindow();
    applyAndCheck(16'h4000, 8'h00, "R2");
    applyAndCheck(16'h7FFF, 8'h02, "R2");
    applyAndCheck(16'h5000, 8'hC2, "R2");
  endtask

  task automatic testHighWindow();
    for (int k = 0; k < 4; k++) begin
      applyAndCheck(16'h8000, 8'(k << 2), "R3");
      applyAndCheck(16'hBFFF, 8'(k << 2) | 8'h40, "R3");
    end
  endtask

  task automatic testTopWindow();
    for (int k = 0; k < 4; k++) begin
      applyAndCheck(16'hC000, 8'(k << 4), "R4");
      applyAndCheck(16'hEFFF, 8'(k << 4) | 8'h80, "R4");
      applyAndCheck(16'hFF05, 8'(k << 4), "R7 boundary");
    end
  endtask

  task automatic testIoPage();
    for (int k = 0; k < 4; k++) begin
      applyAndCheck(16'hD000, 8'(k << 4), "R5");
      applyAndCheck(16'hDFFF, 8'(k << 4) | 8'hC0, "R5");
      applyAndCheck(16'hD800, 8'(k << 4) | 8'h01, "R6");
    end
  endtask

  task automatic testMirror();
    for (int a = 16'hFF00; a <= 16'hFF04; a++) applyAndCheck(16'(a), 8'hFF, "R7");
    applyAndCheck(16'hFEFF, 8'hFF, "R7 boundary");
  endtask

  task automatic testExample();
    applyAndCheck(16'hD000, 8'h10, "R10");
    applyAndCheck(16'h4000, 8'h10, "R10");
    applyAndCheck(16'h8000, 8'h10, "R10");
    applyAndCheck(16'hC000, 8'h10, "R10");
    applyAndCheck(16'hE000, 8'h10, "R10");
    applyAndCheck(16'h0000, 8'h10, "R10");
  endtask

  task automatic testBankSweep();
    for (int c = 0; c < 256; c++)
      for (int w = 0; w < 16; w++)
        applyAndCheck(16'(w << 12) | 16'h0123, 8'(c), "R8 sweep");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testInitial();
    testBottom();
    testLowWindow();
    testHighWindow();
    testTopWindow();
    testIoPage();
    testMirror();
    testExample();
    testBankSweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule